// File: doc/BRIEF.md
# Keyed Configuration Item Port

This block gives boot firmware a narrow window onto a set of configuration items held in an on-chip byte store. Firmware first writes a 16-bit key to the selector. It then streams the chosen item one byte at a time through a data port, and each read moves an internal cursor forward. Keys carry two flag bits beside the item index. One flag picks between two banks of items. The other marks the access as a write channel, through which firmware can fill items that the host has declared writable. When such an item has been filled to its last byte, the block raises a one-cycle completion pulse.

Before firmware runs, the host side defines each item through a preload interface. It gives the item's start address and length in the byte store, and whether the item is writable, and it also loads the item bytes. Bus requests arrive on a valid/ready channel. Each accepted request returns exactly one response on a second valid/ready channel. The block holds only one response at a time, so a consumer that withholds `rsp_ready` stops new requests from being accepted. In split mode the control and data functions sit on separate ports. In shared mode one port serves both, and the access size decides the function.

Top module: `cfg_item_port`

## Requirements
- R1: After reset no response is pending, `done_pulse` is low, and key 0 is selected at offset 0, so data reads with no prior select stream item 0 of bank 0.
- R2: A selector write sets the current key and returns the offset to 0. Key bit 15 is the write-channel flag, bit 14 picks the bank (0 or 1), and bits 13:0 hold the item index.
- R3: A key whose index is at or above NUM_ENTRIES is invalid. Data reads under it return 0, and data writes under it change nothing.
- R4: A data read under a valid key, with offset below the item length, returns the byte at (base + offset) modulo MEM_BYTES and then adds 1 to the offset.
- R5: A data read of an item of length 0, or at an offset at or past the item length, returns 0 and leaves the offset unchanged.
- R6: A data write stores its low byte at (base + offset) and adds 1 to the offset, but only when the key has bit 15 set, the item is writable and the offset is below the length. Otherwise it changes nothing.
- R7: The accepted write that brings the offset up to the item length pulses `done_pulse` high for one cycle in the cycle after acceptance, and returns the offset to 0. No other cycle has `done_pulse` high.
- R8: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. `req_port` encodes 0 = control and 1 = data. In split mode (`shared_mode` = 0) the control port acts only on 2-byte writes (select), and the data port only on 1-byte accesses. Any other access has no effect, and its response data is 0, as it is for every write.
- R9: In shared mode (`shared_mode` = 1), `req_port` is ignored. A 1-byte read or write is a data access, a 2-byte write is a select, and every other access has no effect and returns 0.
- R10: `req_ready` is high exactly when no response is held or the held one is being taken. Each accepted request yields `rsp_valid` in the next cycle. A held response keeps its data stable until `rsp_ready` is high.
- R11: The two banks are separate. The same index with bit 14 set reads a different item definition than with bit 14 clear.
- R12: A preload entry write (`pl_is_entry` = 1) sets the base, length and writable flag of one bank/index slot. A preload byte write (`pl_is_entry` = 0) stores `pl_byte` at `pl_addr`. Both are visible to the next bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shared_mode | input | 1 | 1: one port, function chosen by access size |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 1 | 0 = control, 1 = data (split mode only) |
| req_size | input | 2 | Access size code |
| req_wdata | input | 16 | Write data: key for selects, low byte for data writes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_rdata | output | 8 | Read byte, 0 for writes and rejected accesses |
| done_pulse | output | 1 | One-cycle pulse when a writable item is filled |
| pl_valid | input | 1 | Preload strobe |
| pl_is_entry | input | 1 | 1 = item definition, 0 = store byte |
| pl_bank | input | 1 | Bank of the item definition |
| pl_index | input | log2(NUM_ENTRIES) | Index of the item definition |
| pl_addr | input | log2(MEM_BYTES) | Item base, or byte address for byte preloads |
| pl_len | input | log2(MEM_BYTES)+1 | Item length in bytes |
| pl_writable | input | 1 | Item accepts write-channel bytes |
| pl_byte | input | 8 | Byte for byte preloads |

## Verification
The bench builds the block with NUM_ENTRIES = 4 and MEM_BYTES = 64. With these values the invalid-index boundary is reached with key 4, and an item placed at the top of the store wraps its reads onto address 0 after only a handful of bytes. The small store also lets the bench preload every byte, so each read has a known value. Both split and shared mode are driven through the `shared_mode` pin within one run, and response back-pressure is exercised by holding `rsp_ready` low across a pending request.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int KEY_W        = 16;
  localparam int WR_CHAN_BIT  = 15;
  localparam int BANK_BIT     = 14;
  localparam int INDEX_W      = 14;

  localparam logic PORT_CTL  = 1'b0;
  localparam logic PORT_DATA = 1'b1;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_SELECT = 2'd1,
    OP_READ   = 2'd2,
    OP_WRITE  = 2'd3
  } bus_op_e;
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
(
  input  logic       shared_mode,
  input  logic       req_port,
  input  logic       req_write,
  input  logic [1:0] req_size,
  output bus_op_e    op
);
  acc_size_e size;
  bus_op_e   data_op;

  assign size    = acc_size_e'(req_size);
  assign data_op = req_write ? OP_WRITE : OP_READ;

  always_comb begin
    op = OP_NONE;
    if (shared_mode) begin
      if (size == SZ_BYTE)                  op = data_op;
      else if (size == SZ_HALF && req_write) op = OP_SELECT;
    end else if (req_port == PORT_CTL) begin
      if (size == SZ_HALF && req_write)      op = OP_SELECT;
    end else begin
      if (size == SZ_BYTE)                  op = data_op;
    end
  end
endmodule

// File: rtl/cfgport_cursor.sv
module cfgport_cursor
  import cfgport_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int LEN_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_en,
  input  logic [KEY_W-1:0] sel_key,
  input  logic             adv,
  input  logic             wrap,
  output logic [KEY_W-1:0] key,
  output logic             key_ok,
  output logic [LEN_W-1:0] off
);
  localparam logic [INDEX_W:0] LIMIT = (INDEX_W + 1)'(NUM_ENTRIES);

  logic sel_ok;
  assign sel_ok = {1'b0, sel_key[INDEX_W-1:0]} < LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key    <= '0;
      key_ok <= 1'b1;
      off    <= '0;
    end else if (sel_en) begin
      key    <= sel_key;
      key_ok <= sel_ok;
      off    <= '0;
    end else if (wrap) begin
      off    <= '0;
    end else if (adv) begin
      off    <= off + LEN_W'(1);
    end
  end
endmodule

// File: rtl/cfgport_table.sv
module cfgport_table #(
  parameter int NUM_ENTRIES = 32,
  parameter int ADDR_W      = 8,
  parameter int LEN_W       = 9,
  parameter int IDX_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_en,
  input  logic              pl_bank,
  input  logic [IDX_W-1:0]  pl_index,
  input  logic [ADDR_W-1:0] pl_base,
  input  logic [LEN_W-1:0]  pl_len,
  input  logic              pl_writable,
  input  logic              lk_bank,
  input  logic [IDX_W-1:0]  lk_index,
  output logic [ADDR_W-1:0] lk_base,
  output logic [LEN_W-1:0]  lk_len,
  output logic              lk_writable
);
  localparam int NSLOT  = 2 * NUM_ENTRIES;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam logic [IDX_W:0]    N_LIM   = (IDX_W + 1)'(NUM_ENTRIES);
  localparam logic [SLOT_W-1:0] BANK_OFS = SLOT_W'(NUM_ENTRIES);

  logic [ADDR_W-1:0] base_q [NSLOT];
  logic [LEN_W-1:0]  len_q  [NSLOT];
  logic              wr_q   [NSLOT];

  function automatic logic [SLOT_W-1:0] slot_of(input logic bank, input logic [IDX_W-1:0] idx);
    return SLOT_W'(idx) + (bank ? BANK_OFS : '0);
  endfunction

  logic              pl_hit;
  logic [SLOT_W-1:0] pl_slot;
  logic              lk_hit;
  logic [SLOT_W-1:0] lk_slot;

  assign pl_hit  = pl_en && ({1'b0, pl_index} < N_LIM);
  assign pl_slot = slot_of(pl_bank, pl_index);
  assign lk_hit  = {1'b0, lk_index} < N_LIM;
  assign lk_slot = slot_of(lk_bank, lk_index);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        wr_q[i]   <= 1'b0;
      end
    end else if (pl_hit) begin
      base_q[pl_slot] <= pl_base;
      len_q[pl_slot]  <= pl_len;
      wr_q[pl_slot]   <= pl_writable;
    end
  end

  always_comb begin
    lk_base     = '0;
    lk_len      = '0;
    lk_writable = 1'b0;
    if (lk_hit) begin
      lk_base     = base_q[lk_slot];
      lk_len      = len_q[lk_slot];
      lk_writable = wr_q[lk_slot];
    end
  end
endmodule

// File: rtl/cfgport_store.sv
module cfgport_store #(
  parameter int MEM_BYTES = 256,
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 9
) (
  input  logic              clk,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [7:0]        pl_byte,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_base,
  input  logic [LEN_W-1:0]  bus_off,
  input  logic [7:0]        bus_wbyte,
  output logic [7:0]        bus_rbyte
);
  localparam bit POW2 = (MEM_BYTES & (MEM_BYTES - 1)) == 0;

  logic [7:0]        mem_q [MEM_BYTES];
  logic [ADDR_W-1:0] bus_addr;

  generate
    if (POW2) begin : g_pow2
      logic unused_off_hi;
      assign unused_off_hi = ^bus_off[LEN_W-1:ADDR_W];
      assign bus_addr = bus_base + bus_off[ADDR_W-1:0];
    end else begin : g_mod
      localparam logic [LEN_W:0] MEM_SZ = (LEN_W + 1)'(MEM_BYTES);
      logic [LEN_W:0] sum;
      logic [LEN_W:0] folded;
      assign sum      = (LEN_W + 1)'(bus_base) + (LEN_W + 1)'(bus_off);
      assign folded   = (sum >= MEM_SZ) ? (sum - MEM_SZ) : sum;
      assign bus_addr = folded[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (bus_we)     mem_q[bus_addr] <= bus_wbyte;
    else if (pl_we) mem_q[pl_addr]  <= pl_byte;
  end

  assign bus_rbyte = mem_q[bus_addr];
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfgport_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int MEM_BYTES   = 256,
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int LEN_W      = ADDR_W + 1,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shared_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_port,
  input  logic [1:0]        req_size,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  output logic              done_pulse,
  input  logic              pl_valid,
  input  logic              pl_is_entry,
  input  logic              pl_bank,
  input  logic [IDX_W-1:0]  pl_index,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [LEN_W-1:0]  pl_len,
  input  logic              pl_writable,
  input  logic [7:0]        pl_byte
);
  bus_op_e           dec_op;
  bus_op_e           op;
  logic              fire;
  logic [KEY_W-1:0]  key;
  logic              key_ok;
  logic [LEN_W-1:0]  off;
  logic [ADDR_W-1:0] ent_base;
  logic [LEN_W-1:0]  ent_len;
  logic              ent_wr;
  logic [7:0]        rbyte;
  logic              in_range;
  logic              rd_go;
  logic              wr_go;
  logic              fill_last;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign op        = fire ? dec_op : OP_NONE;

  cfgport_decode u_decode (
    .shared_mode (shared_mode),
    .req_port    (req_port),
    .req_write   (req_write),
    .req_size    (req_size),
    .op          (dec_op)
  );

  cfgport_cursor #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .LEN_W       (LEN_W)
  ) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_en  (op == OP_SELECT),
    .sel_key (req_wdata),
    .adv     (rd_go || wr_go),
    .wrap    (fill_last),
    .key     (key),
    .key_ok  (key_ok),
    .off     (off)
  );

  cfgport_table #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .IDX_W       (IDX_W)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .pl_en       (pl_valid && pl_is_entry),
    .pl_bank     (pl_bank),
    .pl_index    (pl_index),
    .pl_base     (pl_addr),
    .pl_len      (pl_len),
    .pl_writable (pl_writable),
    .lk_bank     (key[BANK_BIT]),
    .lk_index    (key[IDX_W-1:0]),
    .lk_base     (ent_base),
    .lk_len      (ent_len),
    .lk_writable (ent_wr)
  );

  cfgport_store #(
    .MEM_BYTES (MEM_BYTES),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W)
  ) u_store (
    .clk       (clk),
    .pl_we     (pl_valid && !pl_is_entry),
    .pl_addr   (pl_addr),
    .pl_byte   (pl_byte),
    .bus_we    (wr_go),
    .bus_base  (ent_base),
    .bus_off   (off),
    .bus_wbyte (req_wdata[7:0]),
    .bus_rbyte (rbyte)
  );

  logic unused_key_mid;
  assign unused_key_mid = ^key[INDEX_W-1:IDX_W];

  assign in_range  = key_ok && (off < ent_len);
  assign rd_go     = (op == OP_READ) && in_range;
  assign wr_go     = (op == OP_WRITE) && in_range && key[WR_CHAN_BIT] && ent_wr;
  assign fill_last = wr_go && ((off + LEN_W'(1)) == ent_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= fill_last;
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_go ? rbyte : 8'h00;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
  parameter int NUM_ENTRIES = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        shared_mode,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        req_port,
  input logic [1:0]  req_size,
  input logic [15:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_rdata,
  input logic        done_pulse
);
  logic acc;
  logic is_sel;
  logic is_data;
  logic bad_q;
  logic unused_flags;

  assign unused_flags = ^req_wdata[15:14];
  assign acc     = req_valid && req_ready;
  assign is_sel  = acc && req_write && (req_size == 2'd1) && (shared_mode || !req_port);
  assign is_data = acc && (req_size == 2'd0) && (shared_mode || req_port);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bad_q <= 1'b0;
    else if (is_sel) bad_q <= (32'(req_wdata[13:0]) >= NUM_ENTRIES);
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_idle_chk: assert (!rsp_valid && !done_pulse);
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(acc && req_write));

  // R8
  wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write |=> rsp_rdata == 8'h00);

  // R3
  bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q && is_data && !req_write |=> rsp_rdata == 8'h00);

  // R3
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q && is_data |=> !done_pulse);
endmodule

bind cfg_item_port cfg_item_port_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shared_mode (shared_mode),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_port    (req_port),
  .req_size    (req_size),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .done_pulse  (done_pulse)
);

// File: tb/cfg_item_port_bench.sv
module cfg_item_port_bench;
  localparam int NE = 4;
  localparam int MB = 64;
  localparam int AW = 6;
  localparam int LW = 7;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          shared_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_port = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [15:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [7:0]    rsp_rdata;
  logic          done_pulse;
  logic          pl_valid = 1'b0;
  logic          pl_is_entry = 1'b0;
  logic          pl_bank = 1'b0;
  logic [IW-1:0] pl_index = '0;
  logic [AW-1:0] pl_addr = '0;
  logic [LW-1:0] pl_len = '0;
  logic          pl_writable = 1'b0;
  logic [7:0]    pl_byte = '0;

  cfg_item_port #(.NUM_ENTRIES(NE), .MEM_BYTES(MB)) u_cfg_item_port (
    .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_port(req_port), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .done_pulse(done_pulse), .pl_valid(pl_valid), .pl_is_entry(pl_is_entry),
    .pl_bank(pl_bank), .pl_index(pl_index), .pl_addr(pl_addr), .pl_len(pl_len),
    .pl_writable(pl_writable), .pl_byte(pl_byte)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit reported = 0;

  // behavioural reference state
  int m_base [2][NE];
  int m_len  [2][NE];
  bit m_wr   [2][NE];
  int m_mem  [MB];
  int m_key = 0;
  int m_off = 0;
  bit pend_done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic int m_decode(input bit wr, input bit port, input int size);
    if (shared_mode) begin
      if (size == 0) return wr ? 3 : 2;
      if (size == 1 && wr) return 1;
      return 0;
    end
    if (port == 1'b0) return (wr && size == 1) ? 1 : 0;
    return (size == 0) ? (wr ? 3 : 2) : 0;
  endfunction

  task automatic m_apply(input bit wr, input bit port, input int size, input int data,
                         output int rd, output bit dn);
    int op, bank, idx;
    bit ok;
    rd = 0; dn = 0;
    op = m_decode(wr, port, size);
    ok = (m_key & 16'h3FFF) < NE;
    bank = (m_key >> 14) & 1;
    idx  = m_key & 16'h3FFF;
    if (op == 1) begin
      m_key = data & 16'hFFFF;
      m_off = 0;
    end else if (op == 2) begin
      if (ok && m_off < m_len[bank][idx]) begin
        rd = m_mem[(m_base[bank][idx] + m_off) % MB];
        m_off++;
      end
    end else if (op == 3) begin
      if (ok && ((m_key >> 15) & 1) == 1 && m_wr[bank][idx] && m_off < m_len[bank][idx]) begin
        m_mem[(m_base[bank][idx] + m_off) % MB] = data & 8'hFF;
        m_off++;
        if (m_off == m_len[bank][idx]) begin
          dn = 1;
          m_off = 0;
        end
      end
    end
  endtask

  // done_pulse compared against the reference on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 done_pulse", done_pulse, pend_done);
      pend_done = 0;
    end
  end

  task automatic bus(input string req, input bit wr, input bit port, input int size, input int data);
    int rd;
    bit dn;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_port = port;
    req_size = 2'(size); req_wdata = 16'(data);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
    m_apply(wr, port, size, data, rd, dn);
    pend_done = dn;
    @(negedge clk);
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " rsp_rdata"}, rsp_rdata, rd);
  endtask

  task automatic sel(input string req, input int key);
    bus(req, 1, 0, 1, key);
  endtask

  task automatic rd(input string req);
    bus(req, 0, 1, 0, 0);
  endtask

  task automatic wb(input string req, input int b);
    bus(req, 1, 1, 0, b);
  endtask

  task automatic pl_entry(input int bank, input int idx, input int base, input int len, input bit wr);
    @(negedge clk);
    pl_valid = 1; pl_is_entry = 1; pl_bank = bank[0]; pl_index = IW'(idx);
    pl_addr = AW'(base); pl_len = LW'(len); pl_writable = wr;
    @(posedge clk);
    #1 pl_valid = 0;
    m_base[bank][idx] = base; m_len[bank][idx] = len; m_wr[bank][idx] = wr;
  endtask

  task automatic pl_mem(input int addr, input int b);
    @(negedge clk);
    pl_valid = 1; pl_is_entry = 0; pl_addr = AW'(addr); pl_byte = 8'(b);
    @(posedge clk);
    #1 pl_valid = 0;
    m_mem[addr] = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int rda, rdb;
    bit dn;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NE; i++) begin
        m_base[b][i] = 0; m_len[b][i] = 0; m_wr[b][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 done_pulse after reset", done_pulse, 0);
    chk("R1 req_ready after reset", req_ready, 1);

    // R12 preload of store and item definitions
    for (int a = 0; a < MB; a++) pl_mem(a, (a * 3 + 1) & 8'hFF);
    pl_mem(0, 8'hC5); pl_mem(1, 8'h1A); pl_mem(2, 8'h7E); pl_mem(3, 8'h03);
    pl_entry(0, 0, 0, 4, 0);
    pl_entry(0, 1, 8, 5, 0);
    pl_entry(0, 2, 40, 3, 1);
    pl_entry(1, 0, 16, 2, 0);
    pl_entry(1, 1, 62, 4, 0);

    // R1 key 0 streams without a select; R5 past end
    for (int k = 0; k < 4; k++) rd("R1 key0 byte");
    rd("R5 past end");

    // R2 select resets offset
    sel("R2 select", 16'h0001);
    rd("R2 read"); rd("R2 read");
    sel("R2 reselect", 16'h0001);
    rd("R2 first byte again");

    // R11 bank select
    sel("R11 select bank1", 16'h4000);
    for (int k = 0; k < 3; k++) rd("R11 bank1 read");

    // R4 address wrap
    sel("R4 select wrap item", 16'h4001);
    for (int k = 0; k < 4; k++) rd("R4 wrap read");

    // R3 invalid keys
    sel("R3 select idx4", 16'h0004);
    rd("R3 read invalid");
    sel("R3 select idx max", 16'h3FFF);
    rd("R3 read invalid max");
    sel("R3 select wr idx4", 16'h8004);
    wb("R3 write invalid", 8'h5C);

    // R5 empty item
    sel("R5 select empty", 16'h0003);
    rd("R5 read empty");

    // R6 writes gated by channel flag and writable item
    sel("R6 select wr", 16'h8002);
    wb("R6 write", 8'h5A); wb("R6 write", 8'h6B);
    sel("R6 select rd", 16'h0002);
    for (int k = 0; k < 3; k++) rd("R6 readback");
    sel("R6 select no flag", 16'h0002);
    wb("R6 write no flag", 8'h11);
    sel("R6 select ro item", 16'h8001);
    wb("R6 write ro item", 8'h22);
    sel("R6 check ro", 16'h0001);
    rd("R6 ro unchanged");
    sel("R6 check nf", 16'h0002);
    rd("R6 no-flag unchanged");

    // R7 completion pulse and offset return
    sel("R7 select", 16'h8002);
    wb("R7 write", 8'h01); wb("R7 write", 8'h02); wb("R7 fill", 8'h03);
    wb("R7 after wrap", 8'h44);
    sel("R7 readback", 16'h0002);
    for (int k = 0; k < 3; k++) rd("R7 readback");

    // R8 split-mode access sizes
    sel("R8 select", 16'h0001);
    rd("R8 read");
    bus("R8 ctl read", 0, 0, 1, 0);
    bus("R8 ctl 1B write", 1, 0, 0, 16'h0000);
    bus("R8 ctl 4B write", 1, 0, 2, 16'h0000);
    rd("R8 continues");
    bus("R8 data 2B read", 0, 1, 1, 0);
    bus("R8 data 8B read", 0, 1, 3, 0);
    bus("R8 data 2B write", 1, 1, 1, 16'h0000);
    rd("R8 continues");

    // R9 shared mode
    @(negedge clk);
    shared_mode = 1;
    bus("R9 2B write selects", 1, 1, 1, 16'h4000);
    bus("R9 1B read", 0, 0, 0, 0);
    bus("R9 2B read none", 0, 0, 1, 0);
    bus("R9 4B write none", 1, 1, 2, 16'h0000);
    bus("R9 1B read", 0, 1, 0, 0);
    bus("R9 select wr", 1, 0, 1, 16'h8002);
    bus("R9 1B write", 1, 0, 0, 8'h99);
    bus("R9 select rd", 1, 1, 1, 16'h0002);
    bus("R9 readback", 0, 1, 0, 0);
    @(negedge clk);
    shared_mode = 0;

    // R10 response back-pressure
    sel("R10 select", 16'h0001);
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_port = 1; req_size = 2'd0; req_wdata = '0;
    @(posedge clk);
    #1;
    m_apply(0, 1, 0, 0, rda, dn);
    @(negedge clk);
    chk("R10 held valid", rsp_valid, 1);
    chk("R10 held data", rsp_rdata, rda);
    chk("R10 ready low", req_ready, 0);
    repeat (2) begin
      @(negedge clk);
      chk("R10 still held", rsp_rdata, rda);
      chk("R10 still blocked", req_ready, 0);
    end
    rsp_ready = 1;
    @(posedge clk);
    #1 req_valid = 0;
    m_apply(0, 1, 0, 0, rdb, dn);
    @(negedge clk);
    chk("R10 next response", rsp_rdata, rdb);
    chk("R10 next valid", rsp_valid, 1);

    // R12 redefinition visible to the next access
    pl_entry(0, 1, 8, 2, 0);
    pl_mem(9, 8'hE4);
    sel("R12 select", 16'h0001);
    for (int k = 0; k < 3; k++) rd("R12 redefined read");

    repeat (3) @(negedge clk);
    report();
  end
endmodule